// File: doc/BRIEF.md
# Serial-to-Parallel Register with Held Output Stage

This block turns a serial bit stream into a parallel word. Bits arrive one at a time on a serial input and march through a chain of shift stages, one place per rising edge of a shift clock. A second, independently clocked storage register takes a snapshot of the whole chain on a rising edge of a storage clock. The parallel pins therefore show the last snapshot and stay steady while the next word is being shifted in. Display and indicator drivers use it this way: they shift slowly and then update every pin at once, so no intermediate patterns appear.

The parallel pins can be released to high impedance by an active-low enable. A cascade pin always carries the last shift stage, so several of these blocks can be chained on one serial line. An active-low clear empties the shift chain at once without a clock. It leaves the storage register alone, so the pins go to zero only after a storage edge that captures the empty chain. A separate active-low power-on reset can optionally zero the storage register. A parameter selects whether that reset is present.

Top module: `sipo_latched_out`

## Requirements
- R1: On each rising edge of `shift_clk`, stage 0 (shown on `par_out[0]` after a store) takes `ser_in`, and each stage k takes the old value of stage k-1, up to stage WIDTH-1.
- R2: A falling edge of `shift_clk` changes no shift stage, and `ser_in` changes while the clock is high are not captured.
- R3: On each rising edge of `store_clk`, the storage register takes all shift stages at once. A falling edge of `store_clk` and any number of shift edges leave the storage register unchanged.
- R4: While `clear_n` is low, every shift stage is 0 at once with no clock, and `cascade_out` reads 0. The storage register and `par_out` keep their values until the next `store_clk` rising edge.
- R5: With `oe_n` high, all `par_out` bits are undriven (high impedance). With `oe_n` low, `par_out` drives the storage register.
- R6: `cascade_out` always equals the last shift stage (WIDTH-1), whatever the level of `oe_n`.
- R7: When `store_clk` is the same signal as `shift_clk`, after each pulse the storage register holds the shift contents from before that pulse. The storage register lags by one pulse.
- R8: With the power-on reset variant (default), `por_n` low zeroes the storage register at once and leaves the shift stages untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; rising edge advances the chain |
| store_clk | input | 1 | Storage clock; rising edge captures the chain |
| clear_n | input | 1 | Active-low asynchronous clear of the shift chain only |
| por_n | input | 1 | Active-low asynchronous power-on reset of the storage register |
| ser_in | input | 1 | Serial data input |
| oe_n | input | 1 | Active-low enable of the parallel pins |
| par_out | output | WIDTH | Parallel pins, storage register or high impedance |
| cascade_out | output | 1 | Last shift stage, for chaining to the next device |

## Verification
The two functions that can land in the same cycle are a shift and a capture. They meet when both clocks rise together, and they interleave when the two clocks run at unrelated rates. The tied case is provoked by routing the shift pulse onto the storage clock as well. After each pulse, the parallel pins must show the chain as it stood before that pulse, never after it. The interleaved case runs both clocks concurrently at different periods. Every captured word must match a bench model in which each capture sees only the shifts that rose before it.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
   typedef enum logic {
      ST_RST_NONE = 1'b0,
      ST_RST_POR  = 1'b1
   } st_rst_e;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             shift_clk,
   input  logic             clear_n,
   input  logic             ser_in,
   output logic [WIDTH-1:0] stage_q,
   output logic             casc_o
);
   localparam int unsigned LAST = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sipo_shift_chain: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_nxt;
   assign stage_nxt = {stage_q[LAST-1:0], ser_in};

   always_ff @(posedge shift_clk or negedge clear_n) begin
      if (!clear_n) stage_q <= '0;
      else          stage_q <= stage_nxt;
   end

   assign casc_o = stage_q[LAST];

   // marks the first shift edge after a clear, where history is not valid
   logic clr_hit;
   always_ff @(posedge shift_clk or negedge clear_n) begin
      if (!clear_n) clr_hit <= 1'b1;
      else          clr_hit <= 1'b0;
   end

   p_entry_r1: assert property (@(posedge shift_clk) disable iff (!clear_n)
      !clr_hit |-> stage_q[0] == $past(ser_in));

   p_advance_r1: assert property (@(posedge shift_clk) disable iff (!clear_n)
      !clr_hit |-> stage_q[LAST:1] == $past(stage_q[LAST-1:0]));

   p_cascade_r6: assert property (@(posedge shift_clk) disable iff (!clear_n)
      !clr_hit |-> casc_o == $past(stage_q[LAST-1]));
endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg
   import sipo_pkg::*;
#(
   parameter int unsigned WIDTH    = 8,
   parameter st_rst_e     RST_MODE = ST_RST_POR
) (
   input  logic             store_clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (RST_MODE == ST_RST_POR) begin : g_por
         always_ff @(posedge store_clk or negedge por_n) begin
            if (!por_n) q <= '0;
            else        q <= d;
         end

         logic por_hit;
         always_ff @(posedge store_clk or negedge por_n) begin
            if (!por_n) por_hit <= 1'b1;
            else        por_hit <= 1'b0;
         end

         p_capture_r3: assert property (@(posedge store_clk) disable iff (!por_n)
            !por_hit |-> q == $past(d));

         p_por_zero_r8: assert property (@(posedge store_clk)
            !por_n |-> q == '0);
      end else begin : g_plain
         always_ff @(posedge store_clk) q <= d;
      end
   endgenerate
endmodule

// File: rtl/sipo_bus_drv.sv
module sipo_bus_drv #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             oe_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] bus_o
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         assign bus_o[i] = oe_n ? 1'bz : d[i];
      end
   endgenerate
endmodule

// File: rtl/sipo_latched_out.sv
module sipo_latched_out
   import sipo_pkg::*;
#(
   parameter int unsigned WIDTH    = 8,
   parameter st_rst_e     RST_MODE = ST_RST_POR
) (
   input  logic             shift_clk,
   input  logic             store_clk,
   input  logic             clear_n,
   input  logic             por_n,
   input  logic             ser_in,
   input  logic             oe_n,
   output logic [WIDTH-1:0] par_out,
   output logic             cascade_out
);
   logic [WIDTH-1:0] chain_q;
   logic [WIDTH-1:0] held_q;

   sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
      .shift_clk (shift_clk),
      .clear_n   (clear_n),
      .ser_in    (ser_in),
      .stage_q   (chain_q),
      .casc_o    (cascade_out)
   );

   sipo_store_reg #(.WIDTH(WIDTH), .RST_MODE(RST_MODE)) u_store (
      .store_clk (store_clk),
      .por_n     (por_n),
      .d         (chain_q),
      .q         (held_q)
   );

   sipo_bus_drv #(.WIDTH(WIDTH)) u_drv (
      .oe_n  (oe_n),
      .d     (held_q),
      .bus_o (par_out)
   );

   p_clear_r4: assert property (@(posedge shift_clk) disable iff (!por_n)
      !clear_n |-> cascade_out == 1'b0);
endmodule

// File: tb/sipo_latched_out_tb_top.sv
`timescale 1ns/1ps
module sipo_latched_out_tb_top;
   localparam int W = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz reference

   logic sh_drv = 1'b0, st_drv = 1'b0, tie = 1'b0;
   logic clear_n = 1'b0, por_n = 1'b0, ser_in = 1'b0, oe_n = 1'b0;
   logic store_clk;
   wire  [W-1:0] par_bus;
   wire  casc;

   assign store_clk = tie ? sh_drv : st_drv;

   for (genvar i = 0; i < W; i++) begin : g_pu
      pullup (par_bus[i]);
   end

   sipo_latched_out dut_i (
      .shift_clk (sh_drv), .store_clk (store_clk), .clear_n (clear_n),
      .por_n (por_n), .ser_in (ser_in), .oe_n (oe_n),
      .par_out (par_bus), .cascade_out (casc)
   );

   int n_chk = 0, n_fail = 0;
   logic [W-1:0] exp_sh = '0, exp_st = '0;
   bit done = 0;

   task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic sh_pulse(input logic b);
      ser_in = b; #2;
      sh_drv = 1'b1; exp_sh = {exp_sh[W-2:0], b}; #4;
      sh_drv = 1'b0; #2;
   endtask

   task automatic st_pulse();
      st_drv = 1'b1; exp_st = exp_sh; #4;
      st_drv = 1'b0; #4;
   endtask

   task automatic load(input logic [W-1:0] v);
      for (int i = W-1; i >= 0; i--) sh_pulse(v[i]);
   endtask

   task automatic t_reset();
      #10; clear_n = 1'b1; por_n = 1'b1; #2;
      chk("R8 storage zero after reset", par_bus, '0);
      chk("R4 cascade zero after clear", {7'd0, casc}, '0);
   endtask

   task automatic t_shift();
      logic [W-1:0] pat = 8'b1011_0010;
      for (int i = W-1; i >= 0; i--) begin
         sh_pulse(pat[i]); #1;
         chk("R6 cascade is last stage", {7'd0, casc}, {7'd0, exp_sh[W-1]});
         chk("R3 pins steady while shifting", par_bus, exp_st);
      end
      st_pulse(); #1;
      chk("R1 shifted word captured", par_bus, pat);
      chk("R3 capture", par_bus, exp_st);
   endtask

   task automatic t_edges();
      ser_in = 1'b1; #2; sh_drv = 1'b1; exp_sh = {exp_sh[W-2:0], 1'b1}; #2;
      ser_in = 1'b0; #2; sh_drv = 1'b0; #2;   // R2: late change and falling edge ignored
      st_pulse(); #1;
      chk("R2 falling edge ignored", par_bus, exp_st);
      st_drv = 1'b1; exp_st = exp_sh; #4;
      sh_pulse(1'b0); sh_pulse(1'b1);
      st_drv = 1'b0; #2;                       // R3: falling storage edge keeps old word
      chk("R3 falling store edge ignored", par_bus, exp_st);
   endtask

   task automatic t_clear();
      load(8'hFF); st_pulse(); #1;
      chk("R3 load all ones", par_bus, 8'hFF);
      clear_n = 1'b0; exp_sh = '0; #1;
      chk("R4 cascade cleared without clock", {7'd0, casc}, '0);
      chk("R4 storage kept during clear", par_bus, 8'hFF);
      #3; clear_n = 1'b1; #2;
      chk("R4 storage kept after clear", par_bus, 8'hFF);
      st_pulse(); #1;
      chk("R4 store edge captures cleared chain", par_bus, 8'h00);
   endtask

   task automatic t_oe();
      oe_n = 1'b1; #1;
      chk("R5 disabled pins undriven (pulled high)", par_bus, 8'hFF);
      load(8'h81); st_pulse(); #1;
      chk("R5 undriven while disabled", par_bus, 8'hFF);
      chk("R6 cascade active while disabled", {7'd0, casc}, 8'h01);
      oe_n = 1'b0; #1;
      chk("R5 enabled pins drive storage", par_bus, 8'h81);
      load(8'h3C); st_pulse(); oe_n = 1'b1; #1;
      chk("R5 zeros not driven when disabled", par_bus, 8'hFF);
      oe_n = 1'b0; #1;
      chk("R5 re-enabled", par_bus, 8'h3C);
   endtask

   task automatic t_tied();
      logic [W-1:0] pat = 8'b0110_1101;
      tie = 1'b1; #2;
      for (int i = W-1; i >= 0; i--) begin
         exp_st = exp_sh;   // captured value is the chain before this pulse
         sh_pulse(pat[i]); #1;
         chk("R7 tied clocks lag one pulse", par_bus, exp_st);
      end
      tie = 1'b0; #2;
   endtask

   task automatic t_concurrent();
      logic [15:0] pat = 16'hC5A3;
      fork
         begin
            for (int i = 15; i >= 0; i--) sh_pulse(pat[i]);
         end
         begin
            #3;
            for (int k = 0; k < 6; k++) begin
               st_pulse(); #12;
               chk("R3 capture amid shifting", par_bus, exp_st);
            end
         end
      join
      st_pulse(); #1;
      chk("R1 final word after interleaving", par_bus, pat[7:0]);
   endtask

   task automatic t_por();
      load(8'hA7); st_pulse(); #1;
      por_n = 1'b0; #1;
      chk("R8 storage zeroed by power-on reset", par_bus, 8'h00);
      chk("R8 shift chain untouched", {7'd0, casc}, 8'h01);
      por_n = 1'b1; #2; exp_st = '0;
      st_pulse(); #1;
      chk("R8 chain intact after reset", par_bus, 8'hA7);
   endtask

   initial begin
      t_reset();
      t_shift();
      t_edges();
      t_clear();
      t_oe();
      t_tied();
      t_concurrent();
      t_por();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule